// File: doc/BRIEF.md
# Peak Cancellation Pulse Engine

This block is a single cancellation engine for one stage of a peak-cancellation crest factor reducer. A peak detector elsewhere in the stage fires `start` together with a complex clip scale, which is the excess of the peak over the threshold with the peak's phase. On that start the engine latches the scale and the selected coefficient set. It then plays a stored cancellation pulse: once per clock it emits the complex product of the latched scale and one pulse coefficient. The stream is the correction contribution of that one peak. A surrounding adder sums several engines and subtracts the result from a delay-matched copy of the signal. That adder is not part of this block.

The pulse has odd length and is conjugate symmetric about its centre tap. Only the first half, up to and including the centre, is stored. The engine walks the stored words upward to the centre and then back down, and negates the imaginary part on the way down. Up to four pulse sets share one internal memory. The memory is filled through a plain write port. A pulse runs from start to finish with the scale and set it began with. A start that arrives while a pulse is playing is dropped. A build-time switch selects real coefficients, which need two multiplies per sample, or complex coefficients, which need four.

Top module: `pcancel_engine`

## Requirements
- R1: A `start` sampled high at a rising edge while `busy` is low is accepted. `busy` is then high for exactly PULSE_LEN cycles, beginning right after that edge. Afterwards it is low and a new start can be accepted at once.
- R2: The sample for tap 0 appears on the outputs three rising edges after the accepting edge. `out_valid` is then high for exactly PULSE_LEN consecutive cycles, one tap per cycle.
- R3: PULSE_LEN is 127, 255 or 511, and K = PULSE_LEN-1. Tap n, for n in 0..K, reads stored word n when n <= K/2 and word K-n otherwise. Word 0 is the outermost tap and word K/2 is the centre tap, which is played once.
- R4: With COMPLEX=1 each stored word holds (re, im). Taps past the centre use (re, -im). The outputs are out_i = si*re - sq*im and out_q = si*im + sq*re. With COMPLEX=0 the imaginary part is taken as zero.
- R5: Coefficients are signed COEF_W-bit values with COEF_W-1 fraction bits. Each output is the exact sum divided by 2^(COEF_W-1), rounded by adding 2^(COEF_W-2) and taking the floor, then saturated to the signed DATA_W range.
- R6: The set index `set_sel` (0..3, binary) is sampled only at the accepting edge. Changing it during a pulse has no effect on that pulse.
- R7: A `start` while `busy` is high is ignored. The pulse keeps its scale and set and is neither restarted nor lengthened.
- R8: Whenever `out_valid` is low, `out_i` and `out_q` are zero.
- R9: A cycle with `wr_en` high writes (`wr_re`, `wr_im`) into word `wr_addr` of set `wr_set`. Pulses that start afterwards use the new word.
- R10: The clip scale (`scale_i`, `scale_q`) is sampled only at the accepting edge. Later changes do not alter the running pulse.
- R11: A synchronous `rst` aborts any pulse. After the edge where `rst` is high, `busy` and `out_valid` are low and the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to play one pulse |
| set_sel | input | SET_W (2) | Pulse set used by the next accepted start |
| scale_i | input | DATA_W | Clip scale, in-phase part |
| scale_q | input | DATA_W | Clip scale, quadrature part |
| wr_en | input | 1 | Coefficient write strobe |
| wr_set | input | SET_W (2) | Set being written |
| wr_addr | input | ADDR_W | Word within the set, 0 = outer tap, K/2 = centre |
| wr_re | input | COEF_W | Real part of the written coefficient |
| wr_im | input | COEF_W | Imaginary part, ignored when COMPLEX=0 |
| busy | output | 1 | High while a pulse is playing |
| out_valid | output | 1 | Output sample valid |
| out_i | output | DATA_W | Correction sample, in-phase |
| out_q | output | DATA_W | Correction sample, quadrature |

## Verification
The hardest case to reach from the ports is a new start in the first cycle after `busy` falls. At that moment the last taps of the old pulse are still in the multiply pipeline, so the latched scale must not disturb them. The bench reaches this case by polling `busy` on falling edges and raising `start` in the same half-cycle that it first reads low. The bench also has a set whose words sit at the coefficient extremes. Combined with full-scale clip values, that set drives both rounding and saturation, and it forces the negation of the most negative imaginary part on the descending half.

// File: rtl/pce_pkg.sv
package pce_pkg;

  typedef enum logic {
    SEQ_IDLE = 1'b0,
    SEQ_PLAY = 1'b1
  } seq_state_e;

  // Scale an accumulator down by 2^frac with round-half-up, clamp to dw bits.
  function automatic longint round_sat(input longint acc, input int frac, input int dw);
    longint r;
    longint hi;
    longint lo;
    r  = (acc + (longint'(1) <<< (frac - 1))) >>> frac;
    hi = (longint'(1) <<< (dw - 1)) - 1;
    lo = -(longint'(1) <<< (dw - 1));
    if (r > hi)      r = hi;
    else if (r < lo) r = lo;
    return r;
  endfunction

endpackage

// File: rtl/pce_coef_ram.sv
module pce_coef_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  parameter int AW    = 8
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] mem [DEPTH];

  // Simple dual port, registered read: maps onto one block RAM.
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/pce_sequencer.sv
module pce_sequencer
  import pce_pkg::*;
#(
  parameter int PULSE_LEN = 127,
  parameter int DATA_W    = 16,
  parameter int SET_W     = 2,
  parameter int ADDR_W    = 6
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SET_W-1:0]         set_sel,
  input  logic signed [DATA_W-1:0] scale_i,
  input  logic signed [DATA_W-1:0] scale_q,
  output logic                     busy,
  output logic [SET_W-1:0]         rd_set,
  output logic [ADDR_W-1:0]        rd_addr,
  output logic                     rd_desc,
  output logic signed [DATA_W-1:0] scale_i_q,
  output logic signed [DATA_W-1:0] scale_q_q
);

  localparam int CNT_W = $clog2(PULSE_LEN);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(PULSE_LEN - 1);
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(PULSE_LEN / 2);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  logic             accept;

  assign accept = (state_q == SEQ_IDLE) && start;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        SEQ_IDLE: begin
          if (start) begin
            state_q <= SEQ_PLAY;
            cnt_q   <= '0;
          end
        end
        SEQ_PLAY: begin
          if (cnt_q == LAST_C) state_q <= SEQ_IDLE;
          else                 cnt_q   <= cnt_q + CNT_W'(1);
        end
      endcase
    end
  end

  // Scale and set are captured only when a pulse is accepted.
  always_ff @(posedge clk) begin
    if (rst) begin
      scale_i_q <= '0;
      scale_q_q <= '0;
      rd_set    <= '0;
    end else if (accept) begin
      scale_i_q <= scale_i;
      scale_q_q <= scale_q;
      rd_set    <= set_sel;
    end
  end

  always_comb begin
    busy    = (state_q == SEQ_PLAY);
    rd_desc = (cnt_q > HALF_C);
    rd_addr = rd_desc ? ADDR_W'(LAST_C - cnt_q) : ADDR_W'(cnt_q);
  end

  p_accept_r1: assert property (@(posedge clk) disable iff (rst)
    (!busy && start) |=> busy);

  p_ignore_start_r7: assert property (@(posedge clk) disable iff (rst)
    (busy && start && (cnt_q != LAST_C)) |=> (busy && $stable(scale_i_q) && $stable(scale_q_q)));

  p_set_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(rd_set));

  p_scale_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> ($stable(scale_i_q) && $stable(scale_q_q)));

  p_centre_once_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && rd_desc) |-> (rd_addr != ADDR_W'(PULSE_LEN / 2)));

endmodule

// File: rtl/pce_cmult.sv
module pce_cmult
  import pce_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int COEF_W  = 16,
  parameter int COMPLEX = 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_valid,
  input  logic                     neg,
  input  logic signed [DATA_W-1:0] si,
  input  logic signed [DATA_W-1:0] sq,
  input  logic signed [COEF_W-1:0] coef_re,
  input  logic signed [COEF_W-1:0] coef_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);

  localparam int CX = COEF_W + 1;       // room to negate the most negative code
  localparam int PW = DATA_W + CX;
  localparam int SW = PW + 1;

  logic                 prod_valid;
  logic signed [CX-1:0] hr_x;
  logic signed [SW-1:0] acc_i;
  logic signed [SW-1:0] acc_q;

  assign hr_x = CX'(coef_re);

  always_ff @(posedge clk) begin
    if (rst) prod_valid <= 1'b0;
    else     prod_valid <= in_valid;
  end

  if (COMPLEX != 0) begin : g_complex
    logic signed [CX-1:0] hi_x;
    logic signed [PW-1:0] p_rr, p_qi, p_ri, p_qr;

    assign hi_x = neg ? -CX'(coef_im) : CX'(coef_im);

    always_ff @(posedge clk) begin
      p_rr <= PW'(si) * PW'(hr_x);
      p_qi <= PW'(sq) * PW'(hi_x);
      p_ri <= PW'(si) * PW'(hi_x);
      p_qr <= PW'(sq) * PW'(hr_x);
    end

    assign acc_i = SW'(p_rr) - SW'(p_qi);
    assign acc_q = SW'(p_ri) + SW'(p_qr);
  end else begin : g_real
    logic signed [PW-1:0] p_rr, p_qr;
    logic unused_real;

    assign unused_real = neg ^ (^coef_im);

    always_ff @(posedge clk) begin
      p_rr <= PW'(si) * PW'(hr_x);
      p_qr <= PW'(sq) * PW'(hr_x);
    end

    assign acc_i = SW'(p_rr);
    assign acc_q = SW'(p_qr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= prod_valid;
      if (prod_valid) begin
        out_i <= DATA_W'(round_sat(longint'(acc_i), COEF_W - 1, DATA_W));
        out_q <= DATA_W'(round_sat(longint'(acc_q), COEF_W - 1, DATA_W));
      end else begin
        out_i <= '0;
        out_q <= '0;
      end
    end
  end

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !out_valid |-> (out_i == '0 && out_q == '0));

  p_two_stage_r2: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> ##2 out_valid);

endmodule

// File: rtl/pcancel_engine.sv
module pcancel_engine #(
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 16,
  parameter int PULSE_LEN = 127,
  parameter int NUM_SETS  = 4,
  parameter int COMPLEX   = 1,
  localparam int HALF     = PULSE_LEN / 2,
  localparam int WORDS    = HALF + 1,
  localparam int ADDR_W   = $clog2(WORDS),
  localparam int SET_W    = $clog2(NUM_SETS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic [SET_W-1:0]         set_sel,
  input  logic signed [DATA_W-1:0] scale_i,
  input  logic signed [DATA_W-1:0] scale_q,
  input  logic                     wr_en,
  input  logic [SET_W-1:0]         wr_set,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic signed [COEF_W-1:0] wr_re,
  input  logic signed [COEF_W-1:0] wr_im,
  output logic                     busy,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_i,
  output logic signed [DATA_W-1:0] out_q
);

  localparam int RAM_AW = SET_W + ADDR_W;
  localparam int RAM_D  = NUM_SETS * WORDS;
  localparam int RAM_W  = (COMPLEX != 0) ? 2 * COEF_W : COEF_W;

  logic [SET_W-1:0]         seq_set;
  logic [ADDR_W-1:0]        seq_addr;
  logic                     seq_desc;
  logic signed [DATA_W-1:0] lat_i, lat_q;
  logic [RAM_W-1:0]         ram_wdata, ram_rdata;
  logic signed [COEF_W-1:0] rd_re, rd_im;
  logic                     tap_valid_q, tap_desc_q;

  pce_sequencer #(
    .PULSE_LEN(PULSE_LEN), .DATA_W(DATA_W), .SET_W(SET_W), .ADDR_W(ADDR_W)
  ) u_seq (
    .clk(clk), .rst(rst), .start(start), .set_sel(set_sel),
    .scale_i(scale_i), .scale_q(scale_q),
    .busy(busy), .rd_set(seq_set), .rd_addr(seq_addr), .rd_desc(seq_desc),
    .scale_i_q(lat_i), .scale_q_q(lat_q)
  );

  if (COMPLEX != 0) begin : g_cx_store
    assign ram_wdata = {wr_im, wr_re};
    assign rd_re     = ram_rdata[COEF_W-1:0];
    assign rd_im     = ram_rdata[2*COEF_W-1:COEF_W];
  end else begin : g_re_store
    logic unused_wr_im;
    assign unused_wr_im = ^wr_im;
    assign ram_wdata    = wr_re;
    assign rd_re        = ram_rdata;
    assign rd_im        = '0;
  end

  pce_coef_ram #(
    .WIDTH(RAM_W), .DEPTH(RAM_D), .AW(RAM_AW)
  ) u_ram (
    .clk(clk), .wr_en(wr_en), .wr_addr({wr_set, wr_addr}), .wr_data(ram_wdata),
    .rd_addr({seq_set, seq_addr}), .rd_data(ram_rdata)
  );

  // Align tap valid and descending flag with the registered RAM output.
  always_ff @(posedge clk) begin
    if (rst) begin
      tap_valid_q <= 1'b0;
      tap_desc_q  <= 1'b0;
    end else begin
      tap_valid_q <= busy;
      tap_desc_q  <= seq_desc;
    end
  end

  pce_cmult #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COMPLEX(COMPLEX)
  ) u_mult (
    .clk(clk), .rst(rst), .in_valid(tap_valid_q), .neg(tap_desc_q),
    .si(lat_i), .sq(lat_q), .coef_re(rd_re), .coef_im(rd_im),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ##3 out_valid);

endmodule

// File: tb/pcancel_engine_test.sv
module pcancel_engine_test;

  localparam int DW = 16;
  localparam int CW = 16;
  localparam int L  = 127;
  localparam int H  = L / 2;
  localparam int WORDS = H + 1;
  localparam int AW = $clog2(WORDS);
  localparam int SW = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [SW-1:0] set_sel = '0;
  logic signed [DW-1:0] scale_i = '0, scale_q = '0;
  logic wr_en = 1'b0;
  logic [SW-1:0] wr_set = '0;
  logic [AW-1:0] wr_addr = '0;
  logic signed [CW-1:0] wr_re = '0, wr_im = '0;
  logic busy, out_valid;
  logic signed [DW-1:0] out_i, out_q;

  always #5 clk = ~clk;

  pcancel_engine #(.DATA_W(DW), .COEF_W(CW), .PULSE_LEN(L), .NUM_SETS(4), .COMPLEX(1)) uut (
    .clk(clk), .rst(rst), .start(start), .set_sel(set_sel),
    .scale_i(scale_i), .scale_q(scale_q),
    .wr_en(wr_en), .wr_set(wr_set), .wr_addr(wr_addr), .wr_re(wr_re), .wr_im(wr_im),
    .busy(busy), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  string cur_req = "R8";

  longint mre [4][WORDS];
  longint mim [4][WORDS];
  longint exp_i [int];
  longint exp_q [int];
  int edge_n = 0;
  int busy_until = 0;

  function automatic longint rsat(longint acc);
    longint r;
    r = (acc + (longint'(1) <<< (CW - 2))) >>> (CW - 1);
    if (r > 32767) r = 32767;
    if (r < -32768) r = -32768;
    return r;
  endfunction

  task automatic chk(bit ok, string req, string what, longint act, longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at edge %0d", req, what, act, expv, edge_n);
    end
  endtask

  // Behavioural reference: schedules the whole pulse when a start is accepted.
  always @(posedge clk) begin
    edge_n++;
    if (rst) begin
      busy_until = edge_n - 1;
      for (int k = edge_n; k <= edge_n + 2 * L; k++) begin
        if (exp_i.exists(k)) begin
          exp_i.delete(k);
          exp_q.delete(k);
        end
      end
    end else if (start && (edge_n - 1 > busy_until)) begin
      busy_until = edge_n + L - 1;
      for (int n = 0; n < L; n++) begin
        int a;
        longint hr, hi, si, sq;
        a  = (n <= H) ? n : (L - 1 - n);
        hr = mre[set_sel][a];
        hi = (n <= H) ? mim[set_sel][a] : -mim[set_sel][a];
        si = longint'(scale_i);
        sq = longint'(scale_q);
        exp_i[edge_n + 3 + n] = rsat(si * hr - sq * hi);
        exp_q[edge_n + 3 + n] = rsat(si * hi + sq * hr);
      end
    end
  end

  always @(negedge clk) begin
    if (edge_n > 0 && !done) begin
      chk(busy == (edge_n <= busy_until), "R1", "busy",
          longint'(busy), longint'(edge_n <= busy_until));
      if (exp_i.exists(edge_n)) begin
        chk(out_valid == 1'b1, "R2", "out_valid", longint'(out_valid), 1);
        chk(longint'(out_i) == exp_i[edge_n], cur_req, "out_i", longint'(out_i), exp_i[edge_n]);
        chk(longint'(out_q) == exp_q[edge_n], cur_req, "out_q", longint'(out_q), exp_q[edge_n]);
      end else begin
        chk(out_valid == 1'b0, (cur_req == "R11") ? "R11" : "R8", "out_valid idle",
            longint'(out_valid), 0);
        chk(out_i == '0 && out_q == '0, (cur_req == "R11") ? "R11" : "R8", "idle out_i|out_q",
            longint'(out_i) | longint'(out_q), 0);
      end
    end
  end

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_word(int s, int a, longint re, longint im);
    @(negedge clk);
    wr_en = 1'b1; wr_set = SW'(s); wr_addr = AW'(a);
    wr_re = CW'(re); wr_im = CW'(im);
    mre[s][a] = re; mim[s][a] = im;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(int s, longint si, longint sq);
    @(negedge clk);
    start = 1'b1; set_sel = SW'(s); scale_i = DW'(si); scale_q = DW'(sq);
    @(negedge clk);
    start = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8 / R11: reset state, idle outputs
    cur_req = "R8";
    cycles(4);
    rst = 1'b0;
    cycles(3);

    // R9: load all four sets; set 3 holds extreme codes
    cur_req = "R9";
    for (int s = 0; s < 3; s++)
      for (int a = 0; a < WORDS; a++)
        write_word(s, a, ((a * (211 + 37 * s) + 1234 * s) % 30001) - 15000,
                          ((a * (97 + 53 * s) + 777 * s) % 24001) - 12000);
    for (int a = 0; a < WORDS; a++)
      write_word(3, a, (a == 0) ? -32768 : 32767, (a == 0) ? 32767 : -32768);
    cycles(2);

    // R3: address walk up to the centre and back
    cur_req = "R3";
    pulse(0, 12000, 0);
    cycles(L + 6);

    // R4: complex product with conjugate descending half
    cur_req = "R4";
    pulse(1, -9000, 15000);
    cycles(L + 6);

    // R5: rounding and saturation with extreme coefficients
    cur_req = "R5";
    pulse(3, 32767, 32767);
    cycles(L + 6);
    pulse(3, -32768, -32768);
    cycles(L + 6);
    pulse(3, 1, -1);
    cycles(L + 6);

    // R6: set select changes mid-pulse
    cur_req = "R6";
    pulse(2, 20000, -7000);
    cycles(10);
    set_sel = 2'd0;
    cycles(L);

    // R10: scale inputs change mid-pulse
    cur_req = "R10";
    pulse(1, 5000, 5000);
    cycles(7);
    scale_i = -20000; scale_q = 30000;
    cycles(L);

    // R7: second start during busy is dropped, then back-to-back start
    cur_req = "R7";
    pulse(0, -15000, 8000);
    cycles(20);
    pulse(2, 30000, 30000);
    while (busy) @(negedge clk);
    start = 1'b1; set_sel = 2'd1; scale_i = 7777; scale_q = -3333;
    @(negedge clk);
    start = 1'b0;
    cycles(L + 6);

    // R9: rewrite outer and centre words of set 0, then play them
    cur_req = "R9";
    write_word(0, 0, 30000, -25000);
    write_word(0, H, -32768, 0);
    pulse(0, 16000, -16000);
    cycles(L + 6);

    // R11: reset aborts a running pulse, then normal operation resumes
    cur_req = "R11";
    pulse(1, 9000, 9000);
    cycles(30);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    cycles(10);
    cur_req = "R4";
    pulse(1, -4000, 11000);
    cycles(L + 6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule